// File: doc/BRIEF.md
# Mailbox-Commanded Isolated Input Controller

This block interprets byte-coded commands that a host places in a small register window. The host writes operands into outgoing mailbox bytes 0 and 1 and then writes a command code into outgoing byte 2. The block carries out the command on that same clock edge and publishes results and a completion echo in four incoming mailbox bytes. The host reads these bytes through a registered read port. The host never reaches the relays, counters or flags directly. Every setting passes through the command set.

Behind the command set are eight isolated inputs, an eight-bit relay register and eight 16-bit edge counters. The inputs pass through a synchronizer before any logic sees them. Each counter has its own reset value, match value, counting edge and enables. A pattern comparator watches the synchronized inputs. Sticky flags for counter overflow, counter match and pattern match are driven to output pins, where they serve as interrupt requests. Command 0x00 clears all of them.

Top module: `iso_mbox_ctrl`

## Requirements
- R1: A write to outgoing byte index 2 executes the written code at that clock edge. Incoming byte 2 then holds the code itself for a recognised command, or 0xFF for an unrecognised one. An unrecognised code changes no relay, mask, counter or flag state.
- R2: Code 0x01 copies outgoing byte 0 into the relay register, which drives `relay_out`. Code 0x02 places the relay register in incoming byte 0.
- R3: Code 0x00 places the synchronized input levels in incoming byte 3 and clears every overflow, match and pattern flag.
- R4: Code 0x0E returns parameter `FW_VER` and code 0x0F returns parameter `HW_VER`, each with the high byte in incoming byte 1 and the low byte in incoming byte 0.
- R5: Each of the following codes loads a mask from outgoing byte 0: 0x20 filter enable, 0x21 pattern enable, 0x22 pattern value, 0x28 counter enable, 0x2A overflow flag enable, 0x2B match flag enable, 0x2C counting edge. Code 0x07 returns one register in incoming byte 0, chosen by outgoing byte 0: 0 relay, 1 filter enable, 2 pattern enable, 3 pattern value, 4 counter enable, 5 overflow enable, 6 match enable, 7 edge. Any selector above 7 returns 0.
- R6: An enabled counter adds one per edge of its synchronized input. A 0 bit in the edge mask selects rising edges and a 1 bit selects falling edges. A counter whose enable bit is 0 holds its value.
- R7: Codes 0x40+n store {outgoing byte 1, outgoing byte 0} as the reset value of counter n. Code 0x29 loads its reset value into every counter whose bit is set in outgoing byte 0. Code 0x2F returns counter (outgoing byte 0 bits 2:0) with the high byte in incoming byte 1 and the low byte in incoming byte 0.
- R8: A counting edge that arrives while a counter holds 0xFFFF loads the counter's reset value. If the counter's overflow enable bit is set, it also sets bit n of `ovf_irq`.
- R9: Codes 0x48+n store {outgoing byte 1, outgoing byte 0} as the match value of counter n. A count that steps onto the match value sets bit n of `match_irq` when the counter's match enable bit is set.
- R10: `pat_irq` sets on a clock where the pattern enable mask is nonzero and every enabled synchronized input equals the corresponding bit of the pattern value.
- R11: Flags are sticky. They stay set until code 0x00 clears them. A new event that arrives in the same cycle as the clear wins over the clear.
- R12: `host_rdata` shows the incoming byte selected by `host_raddr` one clock after selection. After reset, all incoming bytes, `relay_out` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Write strobe for an outgoing byte |
| host_waddr | input | 2 | Outgoing byte index; index 2 executes a command |
| host_wdata | input | 8 | Write data |
| host_raddr | input | 2 | Incoming byte index |
| host_rdata | output | 8 | Registered incoming byte |
| iso_in | input | 8 | Isolated input levels (asynchronous) |
| relay_out | output | 8 | Relay register |
| ovf_irq | output | 8 | Per-counter overflow flags |
| match_irq | output | 8 | Per-counter match flags |
| pat_irq | output | 1 | Pattern match flag |

## Verification
The assertions assume that operands in outgoing bytes 0 and 1 are written on clocks before the command write, never in the same cycle. They also assume the host does not write a command in the same cycle that a counting edge reaches the counter being read. The stimulus meets these conditions because each byte write is its own host cycle. Inputs are changed only while no command is in flight, and are left steady for several clocks so the synchronizer settles before counters are read. Random register values are confined to the mask, relay and reset-value commands while all inputs are held low, so no counter moves during that phase.

// File: rtl/iso_mbox_pkg.sv
package iso_mbox_pkg;

  localparam int NCH   = 8;
  localparam int CNT_W = 16;
  localparam int IDX_W = $clog2(NCH);

  typedef enum logic [4:0] {
    K_CLR, K_RLY_SET, K_RLY_GET, K_REG_GET, K_FW, K_HW,
    K_FLT, K_PEN, K_PVAL, K_CEN, K_CRLD, K_OVFEN, K_MEN,
    K_EDGE, K_CGET, K_RSTV, K_MATV, K_BAD
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [7:0] c);
    cmd_kind_e k;
    if (c[7:4] == 4'h4) begin
      k = c[3] ? K_MATV : K_RSTV;
    end else begin
      case (c)
        8'h00:   k = K_CLR;
        8'h01:   k = K_RLY_SET;
        8'h02:   k = K_RLY_GET;
        8'h07:   k = K_REG_GET;
        8'h0E:   k = K_FW;
        8'h0F:   k = K_HW;
        8'h20:   k = K_FLT;
        8'h21:   k = K_PEN;
        8'h22:   k = K_PVAL;
        8'h28:   k = K_CEN;
        8'h29:   k = K_CRLD;
        8'h2A:   k = K_OVFEN;
        8'h2B:   k = K_MEN;
        8'h2C:   k = K_EDGE;
        8'h2F:   k = K_CGET;
        default: k = K_BAD;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/iso_in_sync.sv
module iso_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/iso_edge_cnt.sv
module iso_edge_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl,
  input  logic         en,
  input  logic         fall_sel,
  input  logic         reload,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] match_val,
  input  logic         ovf_en,
  input  logic         match_en,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         match_flag
);
  logic         prev_q;
  logic         ev;
  logic         at_top;
  logic [W-1:0] nxt;
  logic         ovf_hit;
  logic         match_hit;

  always_comb begin
    ev        = en && (fall_sel ? (prev_q && !lvl) : (!prev_q && lvl)) && !reload;
    at_top    = (count == {W{1'b1}});
    nxt       = count + 1'b1;
    ovf_hit   = ev && at_top && ovf_en;
    match_hit = ev && !at_top && (nxt == match_val) && match_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      count      <= '0;
      ovf_flag   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (reload)      count <= rst_val;
      else if (ev)     count <= at_top ? rst_val : nxt;
      ovf_flag   <= (ovf_flag && !flag_clr) || ovf_hit;
      match_flag <= (match_flag && !flag_clr) || match_hit;
    end
  end
endmodule

// File: rtl/iso_pat_match.sv
module iso_pat_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en_mask,
  input  logic [W-1:0] value,
  input  logic         flag_clr,
  output logic         flag
);
  logic hit;

  assign hit = (en_mask != '0) && (((lvl ^ value) & en_mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !flag_clr) || hit;
  end
endmodule

// File: rtl/iso_mbox_ctrl.sv
module iso_mbox_ctrl
  import iso_mbox_pkg::*;
#(
  parameter logic [15:0] FW_VER      = 16'h0103,
  parameter logic [15:0] HW_VER      = 16'h0002,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic [1:0] host_waddr,
  input  logic [7:0] host_wdata,
  input  logic [1:0] host_raddr,
  output logic [7:0] host_rdata,
  input  logic [7:0] iso_in,
  output logic [7:0] relay_out,
  output logic [7:0] ovf_irq,
  output logic [7:0] match_irq,
  output logic       pat_irq
);
  localparam logic [1:0] CMD_SLOT = 2'd2;

  logic [7:0]       omb_q [4];
  logic [7:0]       imb_q [4];
  logic [NCH-1:0]   in_sync;
  logic [NCH-1:0]   flt_q, pen_q, pval_q, cen_q, oen_q, men_q, edge_q;
  logic [CNT_W-1:0] rst_val_q [NCH];
  logic [CNT_W-1:0] mat_val_q [NCH];
  logic [CNT_W-1:0] cnt_v     [NCH];
  logic             strobe;
  cmd_kind_e        kind;
  logic [IDX_W-1:0] cmd_idx;
  logic [CNT_W-1:0] opnd;
  logic [NCH-1:0]   reload_v;
  logic             flag_clr;
  logic [7:0]       sel_reg;

  assign strobe   = host_we && (host_waddr == CMD_SLOT);
  assign kind     = decode_cmd(host_wdata);
  assign cmd_idx  = host_wdata[IDX_W-1:0];
  assign opnd     = {omb_q[1], omb_q[0]};
  assign reload_v = (strobe && kind == K_CRLD) ? omb_q[0] : '0;
  assign flag_clr = strobe && (kind == K_CLR);

  always_comb begin
    case (omb_q[0])
      8'd0:    sel_reg = relay_out;
      8'd1:    sel_reg = flt_q;
      8'd2:    sel_reg = pen_q;
      8'd3:    sel_reg = pval_q;
      8'd4:    sel_reg = cen_q;
      8'd5:    sel_reg = oen_q;
      8'd6:    sel_reg = men_q;
      8'd7:    sel_reg = edge_q;
      default: sel_reg = 8'h00;
    endcase
  end

  iso_in_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(iso_in), .q(in_sync)
  );

  // outgoing mailbox bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) omb_q[i] <= 8'h00;
    end else if (host_we) begin
      omb_q[host_waddr] <= host_wdata;
    end
  end

  // per-channel reset and match values
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        rst_val_q[i] <= '0;
        mat_val_q[i] <= '0;
      end
    end else if (strobe) begin
      if (kind == K_RSTV) rst_val_q[cmd_idx] <= opnd;
      if (kind == K_MATV) mat_val_q[cmd_idx] <= opnd;
    end
  end

  // masks and relay register
  always_ff @(posedge clk) begin
    if (rst) begin
      relay_out <= '0;
      flt_q     <= '0;
      pen_q     <= '0;
      pval_q    <= '0;
      cen_q     <= '0;
      oen_q     <= '0;
      men_q     <= '0;
      edge_q    <= '0;
    end else if (strobe) begin
      case (kind)
        K_RLY_SET: relay_out <= omb_q[0];
        K_FLT:     flt_q     <= omb_q[0];
        K_PEN:     pen_q     <= omb_q[0];
        K_PVAL:    pval_q    <= omb_q[0];
        K_CEN:     cen_q     <= omb_q[0];
        K_OVFEN:   oen_q     <= omb_q[0];
        K_MEN:     men_q     <= omb_q[0];
        K_EDGE:    edge_q    <= omb_q[0];
        default:   ;
      endcase
    end
  end

  // incoming mailbox bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) imb_q[i] <= 8'h00;
    end else if (strobe) begin
      imb_q[2] <= (kind == K_BAD) ? 8'hFF : host_wdata;
      case (kind)
        K_CLR:     imb_q[3] <= in_sync;
        K_RLY_GET: imb_q[0] <= relay_out;
        K_REG_GET: imb_q[0] <= sel_reg;
        K_FW:      {imb_q[1], imb_q[0]} <= FW_VER;
        K_HW:      {imb_q[1], imb_q[0]} <= HW_VER;
        K_CGET:    {imb_q[1], imb_q[0]} <= cnt_v[omb_q[0][IDX_W-1:0]];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= 8'h00;
    else     host_rdata <= imb_q[host_raddr];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    iso_edge_cnt #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .lvl       (in_sync[g]),
      .en        (cen_q[g]),
      .fall_sel  (edge_q[g]),
      .reload    (reload_v[g]),
      .rst_val   (rst_val_q[g]),
      .match_val (mat_val_q[g]),
      .ovf_en    (oen_q[g]),
      .match_en  (men_q[g]),
      .flag_clr  (flag_clr),
      .count     (cnt_v[g]),
      .ovf_flag  (ovf_irq[g]),
      .match_flag(match_irq[g])
    );
  end

  iso_pat_match #(.W(NCH)) u_pat (
    .clk(clk), .rst(rst), .lvl(in_sync), .en_mask(pen_q), .value(pval_q),
    .flag_clr(flag_clr), .flag(pat_irq)
  );
endmodule

// File: rtl/iso_mbox_chk.sv
module iso_mbox_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_we,
  input logic [1:0] host_waddr,
  input logic [7:0] host_wdata,
  input logic [1:0] host_raddr,
  input logic [7:0] host_rdata,
  input logic [7:0] relay_out,
  input logic [7:0] ovf_irq,
  input logic [7:0] match_irq,
  input logic       pat_irq,
  input logic [7:0] omb0,
  input logic [7:0] imb0,
  input logic [7:0] imb1,
  input logic [7:0] imb2,
  input logic [7:0] imb3,
  input logic [7:0] oen,
  input logic [7:0] men,
  input logic [7:0] pen
);
  logic       exec;
  logic       clr_cmd;
  logic [7:0] imb_sel;

  assign exec    = host_we && (host_waddr == 2'd2);
  assign clr_cmd = exec && (host_wdata == 8'h00);

  always_comb begin
    case (host_raddr)
      2'd0:    imb_sel = imb0;
      2'd1:    imb_sel = imb1;
      2'd2:    imb_sel = imb2;
      default: imb_sel = imb3;
    endcase
  end

  // R1
  bad_code_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && host_wdata[7:4] == 4'h3) |=> (imb2 == 8'hFF && $stable(relay_out)));

  // R2
  relay_load_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && host_wdata == 8'h01) |=> (relay_out == $past(omb0) && imb2 == 8'h01));

  // R8
  ovf_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_irq & ~$past(ovf_irq) & ~$past(oen)) == 8'h00));

  // R9
  match_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((match_irq & ~$past(match_irq) & ~$past(men)) == 8'h00));

  // R10
  pat_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pat_irq) |-> ($past(pen) != 8'h00));

  // R11
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_cmd |=> (((ovf_irq & $past(ovf_irq)) == $past(ovf_irq)) &&
                  ((match_irq & $past(match_irq)) == $past(match_irq)) &&
                  (pat_irq || !$past(pat_irq))));

  // R12
  read_port_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (host_rdata == $past(imb_sel)));
endmodule

bind iso_mbox_ctrl iso_mbox_chk chk_i (
  .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
  .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
  .relay_out(relay_out), .ovf_irq(ovf_irq), .match_irq(match_irq),
  .pat_irq(pat_irq), .omb0(omb_q[0]), .imb0(imb_q[0]), .imb1(imb_q[1]),
  .imb2(imb_q[2]), .imb3(imb_q[3]), .oen(oen_q), .men(men_q), .pen(pen_q)
);

// File: tb/iso_mbox_ctrl_tb_top.sv
module iso_mbox_ctrl_tb_top;
  localparam logic [15:0] FW = 16'h0103;
  localparam logic [15:0] HW = 16'h0002;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [1:0] host_waddr = '0;
  logic [7:0] host_wdata = '0;
  logic [1:0] host_raddr = '0;
  logic [7:0] host_rdata;
  logic [7:0] iso_in = '0;
  logic [7:0] relay_out, ovf_irq, match_irq;
  logic       pat_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] m_reg [8];

  always #10 clk = ~clk;

  iso_mbox_ctrl #(.FW_VER(FW), .HW_VER(HW)) dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .iso_in(iso_in), .relay_out(relay_out), .ovf_irq(ovf_irq),
    .match_irq(match_irq), .pat_irq(pat_irq)
  );

  function automatic logic [7:0] code_for(input int sel);
    case (sel)
      0: return 8'h01; 1: return 8'h20; 2: return 8'h21; 3: return 8'h22;
      4: return 8'h28; 5: return 8'h2A; 6: return 8'h2B; default: return 8'h2C;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(input int sel);
    return (sel < 8) ? m_reg[sel] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] o0, input logic [7:0] o1);
    wr(2'd0, o0); wr(2'd1, o1); wr(2'd2, c);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_raddr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] hi, lo;
    rd(2'd1, hi); rd(2'd0, lo);
    v = {hi, lo};
  endtask

  task automatic set_in(input logic [7:0] v);
    @(negedge clk); iso_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic cnt_read(input int ch, output logic [15:0] v);
    cmd(8'h2F, 8'(ch), 8'h00); rd16(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), b); chk("R12 reset imb", b, 8'h00);
    end
    chk("R12 reset relay/flags", {relay_out, ovf_irq, match_irq, 7'd0, pat_irq}, 32'h0);

    // R4 versions
    cmd(8'h0E, 8'h00, 8'h00); rd16(v); chk("R4 fw", v, FW);
    cmd(8'h0F, 8'h00, 8'h00); rd16(v); chk("R4 hw", v, HW);
    rd(2'd2, b); chk("R1 echo 0F", b, 8'h0F);

    // R2 R5 random register traffic, inputs quiet
    for (int it = 0; it < 40; it++) begin
      int s = int'($urandom_range(0, 7));
      logic [7:0] val = 8'($urandom);
      cmd(code_for(s), val, 8'($urandom));
      m_reg[s] = val;
      if (s == 0) begin
        chk("R2 relay_out", relay_out, val);
        cmd(8'h02, 8'h00, 8'h00); rd(2'd0, b); chk("R2 relay read", b, val);
      end
      cmd(8'h07, 8'(s), 8'h00); rd(2'd0, b); chk("R5 reg read", b, exp_reg(s));
    end
    cmd(8'h07, 8'd9, 8'h00); rd(2'd0, b); chk("R5 sel above 7", b, exp_reg(9));

    // R7 random reset values, reload, read back
    for (int it = 0; it < 16; it++) begin
      int ch = int'($urandom_range(0, 7));
      logic [15:0] rv = 16'($urandom);
      cmd(8'h40 + 8'(ch), rv[7:0], rv[15:8]);
      cmd(8'h29, 8'(1 << ch), 8'h00);
      cnt_read(ch, v); chk("R7 reload/read", v, rv);
    end

    // R1 unknown code
    b = relay_out;
    cmd(8'h55, 8'hA5, 8'h00);
    rd(2'd2, host_wdata); chk("R1 unknown echo", host_wdata, 8'hFF);
    chk("R1 unknown no relay change", relay_out, b);
    cmd(8'h07, 8'd4, 8'h00); rd(2'd0, b); chk("R1 unknown no mask change", b, m_reg[4]);

    // quiesce masks, clear flags
    for (int s = 1; s < 8; s++) begin cmd(code_for(s), 8'h00, 8'h00); m_reg[s] = 8'h00; end
    cmd(8'h00, 8'h00, 8'h00);
    chk("R3 flags cleared", {ovf_irq, match_irq, 7'd0, pat_irq}, 24'h0);

    // R6 rising edges on ch0, held ch3 disabled
    cmd(8'h40, 8'h00, 8'h00); cmd(8'h43, 8'h05, 8'h00);
    cmd(8'h29, 8'h09, 8'h00);
    cmd(8'h28, 8'h01, 8'h00);
    for (int k = 0; k < 3; k++) begin set_in(8'h09); set_in(8'h00); end
    cnt_read(0, v); chk("R6 rising count", v, 16'd3);
    cnt_read(3, v); chk("R6 disabled holds", v, 16'd5);

    // R6 falling mode on ch4
    cmd(8'h44, 8'h20, 8'h00); cmd(8'h29, 8'h10, 8'h00);
    cmd(8'h2C, 8'h10, 8'h00); cmd(8'h28, 8'h11, 8'h00);
    set_in(8'h10); cnt_read(4, v); chk("R6 falling no count on rise", v, 16'h20);
    set_in(8'h00); cnt_read(4, v); chk("R6 falling count", v, 16'h21);

    // R8 overflow on ch1
    cmd(8'h41, 8'hFE, 8'hFF); cmd(8'h29, 8'h02, 8'h00);
    cmd(8'h2A, 8'h02, 8'h00); cmd(8'h28, 8'h13, 8'h00);
    set_in(8'h02); set_in(8'h00);
    chk("R8 no flag before wrap", ovf_irq, 8'h00);
    set_in(8'h02); set_in(8'h00);
    chk("R8 overflow flag", ovf_irq, 8'h02);
    cnt_read(1, v); chk("R8 wrap reload", v, 16'hFFFE);

    // R9 match on ch2
    cmd(8'h42, 8'h10, 8'h00); cmd(8'h4A, 8'h12, 8'h00);
    cmd(8'h29, 8'h04, 8'h00); cmd(8'h2B, 8'h04, 8'h00); cmd(8'h28, 8'h17, 8'h00);
    set_in(8'h04); set_in(8'h00);
    chk("R9 before match", match_irq, 8'h00);
    set_in(8'h04); set_in(8'h00);
    chk("R9 match flag", match_irq, 8'h04);

    // R11 flags persist without clear
    repeat (5) @(negedge clk);
    chk("R11 sticky", {ovf_irq, match_irq}, 16'h0204);

    // R10 pattern
    cmd(8'h28, 8'h00, 8'h00);
    cmd(8'h22, 8'h05, 8'h00); cmd(8'h21, 8'h0F, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 no match yet", pat_irq, 1'b0);
    set_in(8'h25);
    chk("R10 pattern flag", pat_irq, 1'b1);

    // R3 clear and input snapshot
    set_in(8'h81);
    cmd(8'h00, 8'h00, 8'h00);
    @(negedge clk);
    chk("R3 clear flags", {ovf_irq, match_irq, 7'd0, pat_irq}, 24'h0);
    rd(2'd3, b); chk("R3 input snapshot", b, 8'h81);
    rd(2'd2, b); chk("R1 clear echo", b, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule